// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

A 64-word by 4-bit static RAM in which every word has a nonvolatile shadow copy. The memory is reached through a plain clocked SRAM port: chip enable, write enable, a 6-bit address and 4-bit write and read data. Ordinary reads and writes work only on the working array. Nothing on the port signals a transfer directly. A transfer starts when software reads a fixed chain of six addresses. The last address in the chain selects the direction. One key copies the whole working array into the shadow (STORE). The other clears the working array and then loads it from the shadow (RECALL).

While a transfer runs, `busy_o` is high and the port is locked. Writes are dropped, reads return zero and the sequence detector stops counting. After reset the block waits for the power-good input and then runs an automatic RECALL before it accepts any access. Reset does not clear the shadow array, so its contents survive a reset. STORE and RECALL each last a set number of cycles, given by parameters. STORE is meant to be much longer than RECALL.

The port has no back-pressure. Every access offered while `busy_o` is low is taken in the cycle it is offered. An access offered while `busy_o` is high is discarded, not delayed. The caller must hold off until `busy_o` falls.

Top module: `nvsram_ctrl`

## Requirements
- R1: An access with `ce_i`=1 and `busy_o`=0 is taken at the clock edge. With `we_i`=1 it writes `wdata_i` to word `addr_i`. With `we_i`=0, `rdata_o` shows that word from the next cycle and holds it until the next accepted read.
- R2: After reset `busy_o` is 1 and `rdata_o` is 0 until `pwr_ok_i` is seen high. A RECALL then runs, and it restores the shadow contents, which reset leaves intact.
- R3: The trigger is six accepted reads at addresses 0x0E, 0x31, 0x03, 0x3C and 0x30, in that order, followed by 0x3F for STORE or 0x0C for RECALL. Cycles with `ce_i`=0 between these reads do not break the chain.
- R4: An accepted write at any point in the chain aborts it, and the write still takes effect. A read at any address other than the next expected one also aborts the chain. If that read is at 0x0E, it counts as the first step of a new chain.
- R5: `busy_o` rises in the cycle after the sixth trigger read. It stays high for exactly STORE_CYC cycles for a STORE and exactly RECALL_CYC cycles for a RECALL.
- R6: While `busy_o` is high, writes have no effect, `rdata_o` is 0 and reads do not advance the trigger detector.
- R7: STORE copies every word of the working array into the shadow. Nothing else writes the shadow, including ordinary writes.
- R8: RECALL first clears the working array to zero and then loads every word from the shadow. The shadow is left unchanged, so repeated RECALLs give the same contents.
- R9: The first five reads of a trigger chain return the normal stored data. The chain leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (working array, detector, controller) |
| pwr_ok_i | input | 1 | Power-good indication; starts the power-up RECALL |
| ce_i | input | 1 | Chip enable, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word address |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data, zero while busy |
| busy_o | output | 1 | High while a transfer runs or power is awaited |

## Verification
The bench interrupts trigger chains with a write, with a wrong address and with a restart at the first key. A detector that ignores writes or fails to reset would then start a transfer it should not, and a detector that does not restart on the first key would miss one it should start. It counts `busy_o` cycles on each path, so an off-by-one counter or a lost clear phase shows up as a length mismatch. It writes and reads during STORE, so a design that leaks writes through the lock would corrupt the saved pattern. It overwrites the working array and then resets the block, so a design that resets the shadow or loads the wrong array would lose the saved data.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    XF_IDLE,
    XF_PWR_WAIT,
    XF_STORE,
    XF_RCL_CLR,
    XF_RCL_LOAD
  } xfer_st_t;
endpackage

// File: rtl/nvs_seq_det.sv
module nvs_seq_det #(
  parameter int AW = 6,
  parameter logic [AW-1:0] KEY0 = 6'h0E,
  parameter logic [AW-1:0] KEY1 = 6'h31,
  parameter logic [AW-1:0] KEY2 = 6'h03,
  parameter logic [AW-1:0] KEY3 = 6'h3C,
  parameter logic [AW-1:0] KEY4 = 6'h30,
  parameter logic [AW-1:0] KEY_STORE  = 6'h3F,
  parameter logic [AW-1:0] KEY_RECALL = 6'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_acc_i,
  input  logic          wr_acc_i,
  input  logic [AW-1:0] addr_i,
  output logic          go_store_o,
  output logic          go_recall_o
);
  localparam logic [2:0] LAST = 3'd5;
  localparam logic [7:0][AW-1:0] KEYS =
    {{3{AW'(0)}}, KEY4, KEY3, KEY2, KEY1, KEY0};

  logic [2:0] step_q;
  logic at_last, hit;

  assign at_last     = (step_q == LAST);
  assign hit         = (addr_i == KEYS[step_q]);
  assign go_store_o  = rd_acc_i && at_last && (addr_i == KEY_STORE);
  assign go_recall_o = rd_acc_i && at_last && (addr_i == KEY_RECALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (wr_acc_i) begin
      step_q <= '0;
    end else if (rd_acc_i) begin
      if (!at_last && hit)      step_q <= step_q + 3'd1;
      else if (addr_i == KEY0)  step_q <= 3'd1;
      else                      step_q <= '0;
    end
  end
endmodule

// File: rtl/nvs_xfer_ctl.sv
module nvs_xfer_ctl
  import nvs_pkg::*;
#(
  parameter int STORE_CYC  = 200,
  parameter int RECALL_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok_i,
  input  logic go_store_i,
  input  logic go_recall_i,
  output logic busy_o,
  output logic clr_all_o,
  output logic store_all_o,
  output logic load_all_o
);
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW   = $clog2(MAXC) + 1;

  xfer_st_t st_q;
  logic [CW-1:0] cnt_q;
  logic done;

  assign done        = (cnt_q == '0);
  assign busy_o      = (st_q != XF_IDLE);
  assign clr_all_o   = (st_q == XF_RCL_CLR);
  assign store_all_o = (st_q == XF_STORE) && done;
  assign load_all_o  = (st_q == XF_RCL_LOAD) && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= XF_PWR_WAIT;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        XF_IDLE: begin
          if (go_store_i) begin
            st_q  <= XF_STORE;
            cnt_q <= CW'(STORE_CYC - 1);
          end else if (go_recall_i) begin
            st_q <= XF_RCL_CLR;
          end
        end
        XF_PWR_WAIT: if (pwr_ok_i) st_q <= XF_RCL_CLR;
        XF_STORE: begin
          if (done) st_q <= XF_IDLE;
          else      cnt_q <= cnt_q - 1'b1;
        end
        XF_RCL_CLR: begin
          st_q  <= XF_RCL_LOAD;
          cnt_q <= CW'(RECALL_CYC - 2);
        end
        XF_RCL_LOAD: begin
          if (done) st_q <= XF_IDLE;
          else      cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= XF_IDLE;
      endcase
    end
  end

  // R6
  trig_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_store_i || go_recall_i) |-> (st_q == XF_IDLE));

  // R8
  clr_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_o |=> (st_q == XF_RCL_LOAD));
endmodule

// File: rtl/nvs_cell_array.sv
module nvs_cell_array #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_all_i,
  input  logic          store_all_i,
  input  logic          load_all_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int BITS  = DEPTH * DW;

  logic [BITS-1:0] sram_q;
  logic [BITS-1:0] shadow_q;
  logic [DW-1:0]   rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           sram_q <= '0;
    else if (clr_all_i)   sram_q <= '0;
    else if (load_all_i)  sram_q <= shadow_q;
    else if (wr_en_i)     sram_q[int'(addr_i)*DW +: DW] <= wdata_i;
  end

  // nonvolatile: no reset
  always_ff @(posedge clk) begin
    if (store_all_i) shadow_q <= sram_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= sram_q[int'(addr_i)*DW +: DW];
  end

  assign rdata_o = rd_q;

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store_all_i |=> $stable(shadow_q));

  // R6
  sram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !clr_all_i && !load_all_i) |=> $stable(sram_q));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (sram_q == '0));

  // R7
  one_bulk_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_all_i, store_all_i, load_all_i}));
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int AW = 6,
  parameter int DW = 4,
  parameter int STORE_CYC  = 200,
  parameter int RECALL_CYC = 8,
  parameter logic [AW-1:0] KEY0 = 6'h0E,
  parameter logic [AW-1:0] KEY1 = 6'h31,
  parameter logic [AW-1:0] KEY2 = 6'h03,
  parameter logic [AW-1:0] KEY3 = 6'h3C,
  parameter logic [AW-1:0] KEY4 = 6'h30,
  parameter logic [AW-1:0] KEY_STORE  = 6'h3F,
  parameter logic [AW-1:0] KEY_RECALL = 6'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok_i,
  input  logic          ce_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o
);
  logic busy, rd_acc, wr_acc;
  logic go_store, go_recall, clr_all, store_all, load_all;
  logic [DW-1:0] arr_rdata;

  assign rd_acc = ce_i && !we_i && !busy;
  assign wr_acc = ce_i &&  we_i && !busy;

  nvs_seq_det #(
    .AW(AW), .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3),
    .KEY4(KEY4), .KEY_STORE(KEY_STORE), .KEY_RECALL(KEY_RECALL)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .rd_acc_i(rd_acc), .wr_acc_i(wr_acc),
    .addr_i(addr_i), .go_store_o(go_store), .go_recall_o(go_recall)
  );

  nvs_xfer_ctl #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok_i),
    .go_store_i(go_store), .go_recall_i(go_recall), .busy_o(busy),
    .clr_all_o(clr_all), .store_all_o(store_all), .load_all_o(load_all)
  );

  nvs_cell_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_acc), .rd_en_i(rd_acc),
    .addr_i(addr_i), .wdata_i(wdata_i), .clr_all_i(clr_all),
    .store_all_i(store_all), .load_all_i(load_all), .rdata_o(arr_rdata)
  );

  assign busy_o  = busy;
  assign rdata_o = busy ? '0 : arr_rdata;

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_store || go_recall) |=> busy_o);
endmodule

// File: tb/tb_nvsram_ctrl.sv
module tb_nvsram_ctrl;
  localparam int SC = 200;
  localparam int RC = 8;

  logic clk = 0, rst_n = 0, pwr_ok = 0, ce = 0, we = 0;
  logic [5:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic busy;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nvsram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .ce_i(ce), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy)
  );

  function automatic logic [3:0] pat_a(int a);
    return 4'((a * 5 + 3) & 15);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(int a, logic [3:0] d);
    ce = 1; we = 1; addr = 6'(a); wdata = d; tick(); ce = 0; we = 0;
  endtask

  task automatic rd(int a);
    ce = 1; we = 0; addr = 6'(a); tick(); ce = 0;
  endtask

  task automatic fill(bit inv);
    for (int a = 0; a < 64; a++) wr(a, inv ? ~pat_a(a) : pat_a(a));
  endtask

  task automatic verify(bit inv, string req);
    int bad = 0;
    logic [3:0] first_act = 0, first_exp = 0;
    for (int a = 0; a < 64; a++) begin
      rd(a);
      if (rdata !== (inv ? ~pat_a(a) : pat_a(a))) begin
        if (bad == 0) begin first_act = rdata; first_exp = inv ? ~pat_a(a) : pat_a(a); end
        bad++;
      end
    end
    chk(bad == 0, req, first_act, first_exp);
  endtask

  // first five keys, checking returned data (R9)
  task automatic keys5(bit inv);
    int key[5] = '{6'h0E, 6'h31, 6'h03, 6'h3C, 6'h30};
    for (int i = 0; i < 5; i++) begin
      rd(key[i]);
      chk(rdata === (inv ? ~pat_a(key[i]) : pat_a(key[i])) && !busy,
          "R9 key read data", rdata, inv ? ~pat_a(key[i]) : pat_a(key[i]));
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; tick(); end
  endtask

  task automatic t_power_up();
    int n;
    repeat (3) tick();
    rst_n = 1; repeat (4) tick();
    chk(busy === 1'b1, "R2 busy before power ok", busy, 1);
    rd(3);
    chk(rdata === 4'd0, "R2 rdata zero before power ok", rdata, 0);
    pwr_ok = 1; tick();
    count_busy(n);
    chk(n == RC, "R2 power-up recall length", n, RC);
  endtask

  task automatic t_basic();
    fill(0);
    verify(0, "R1 write/read pattern A");
    wr(9, 4'hA); ce = 0; tick(); tick();
    rd(9); chk(rdata === 4'hA, "R1 single word", rdata, 10);
    tick(); chk(rdata === 4'hA, "R1 rdata held", rdata, 10);
    wr(9, pat_a(9));
  endtask

  task automatic t_store();
    int n;
    keys5(0);
    tick();  // idle gap inside chain (R3)
    rd(6'h3F);
    chk(busy === 1'b1, "R5 busy after store key", busy, 1);
    ce = 1; we = 1; addr = 6'd7; wdata = ~pat_a(7); tick(); ce = 0; we = 0;
    ce = 1; addr = 6'd7; tick(); ce = 0;
    chk(rdata === 4'd0, "R6 rdata zero while busy", rdata, 0);
    count_busy(n);
    chk(n + 2 == SC, "R5 store length", n + 2, SC);
    rd(7); chk(rdata === pat_a(7), "R6 write dropped while busy", rdata, pat_a(7));
  endtask

  task automatic do_recall(string req);
    int n;
    keys5(1);
    rd(6'h0C);
    count_busy(n);
    chk(n == RC, req, n, RC);
  endtask

  task automatic t_recall();
    fill(1);  // ordinary writes must not reach the shadow (R7)
    do_recall("R5 recall length");
    verify(0, "R8 recall restores shadow");
    fill(1);
    do_recall("R5 second recall length");
    verify(0, "R8 shadow unchanged by recall");
  endtask

  task automatic t_abort_write();
    keys5(0); tick();
    rd(6'h0E); rd(6'h31);
    wr(20, 4'h6);
    rd(6'h03); rd(6'h3C); rd(6'h30); rd(6'h3F);
    chk(busy === 1'b0, "R4 write aborts chain", busy, 0);
    rd(20); chk(rdata === 4'h6, "R4 aborting write lands", rdata, 6);
    wr(20, pat_a(20));
  endtask

  task automatic t_abort_read();
    rd(6'h0E); rd(6'h31); rd(6'h03); rd(6'h05);
    rd(6'h3C); rd(6'h30); rd(6'h3F);
    chk(busy === 1'b0, "R4 wrong read aborts chain", busy, 0);
    // restart at first key: 0E 31 0E 31 03 3C 30 0C -> recall
    rd(6'h0E); rd(6'h31); rd(6'h0E); rd(6'h31); rd(6'h03); rd(6'h3C); rd(6'h30);
    chk(busy === 1'b0, "R3 no busy before last key", busy, 0);
    rd(6'h0C);
    chk(busy === 1'b1, "R4 restart on first key starts recall", busy, 1);
    while (busy) tick();
  endtask

  task automatic t_reset_keep();
    int n;
    fill(1);
    rst_n = 0; tick(); tick(); rst_n = 1;
    count_busy(n);
    chk(n == RC + 1, "R2 recall after reset length", n, RC + 1);
    verify(0, "R2 shadow survives reset");
  endtask

  initial begin
    t_power_up();
    t_basic();
    t_store();
    t_recall();
    t_abort_write();
    t_abort_read();
    t_reset_keep();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule